// File: doc/BRIEF.md
# Mixed-Decay Current Chopper Sequencer

This block sequences the four gate enables of one H-bridge so that the winding current is held near a trip level by a fixed off-time chopper. While the bridge is driving, one diagonal is on: the high side of one leg and the low side of the other, chosen by a direction bit. When the external current comparator reports that the trip level is reached, the block starts an off period of fixed length. That period begins with fast decay, in which the opposite diagonal conducts as synchronous rectifiers. After a forced all-off dead time it continues with slow decay, in which both low sides conduct. When the off period ends, the block drives again.

The comparator is ignored for a blanking window at the start of every drive period. Every time a transistor hands over to its partner on the same leg, all gates on that leg are held off for a crossover delay first. A zero-current detect input cuts synchronous rectification for the rest of the off period, so the winding current cannot reverse. A fault input forces every gate off, and so does the coast level code. Every timing is a count of system-clock cycles. The default counts are derived from a 50 MHz clock.

Top module: `decay_chopper`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, all four gates are off. A drive period then begins only after XOVER_CYC consecutive all-off cycles.
- R2: During drive, phase_dir=1 enables hs_a and ls_b, and phase_dir=0 enables hs_b and ls_a. The other two gates are off.
- R3: During the first BLANK_CYC cycles of a drive period, trip_in is ignored. From drive cycle BLANK_CYC onward, trip_in high at a clock edge starts the off period in the next cycle.
- R4: The off period lasts exactly OFF_CYC cycles. It is followed by XOVER_CYC all-off cycles and then a new drive period. The drive uses the direction present on phase_dir when that drive period begins.
- R5: Off-period cycles 0 to XOVER_CYC-1 are all off. Cycles XOVER_CYC to FAST_CYC-1 enable the diagonal opposite to the drive diagonal. FAST_CYC is OFF_CYC*FAST_PERMIL/1000, rounded to the nearest integer.
- R6: Off-period cycles FAST_CYC to FAST_CYC+DEAD_CYC-1 are all off. The remaining off-period cycles enable ls_a and ls_b only.
- R7: If zero_in is high at an edge during the off period, all gates are off from the next cycle until that off period ends.
- R8: A change of phase_dir during drive ends the drive at once. XOVER_CYC all-off cycles follow, then a drive with the new diagonal and a fresh blanking window. A change of phase_dir during the off period does not shorten that off period.
- R9: level_code 2'b11 (coast) forces all gates off from the next cycle for as long as it is held. Codes 2'b00, 2'b01 and 2'b10 all drive the same way. When coast is released, the R1 start-up sequence follows.
- R10: fault_in high forces all gates off from the next cycle. After fault_in falls, the R1 start-up sequence follows.
- R11: The high and low gate of a leg are never on together. A gate turns on only after its partner on the same leg has been off for at least XOVER_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_dir | input | 1 | Drive direction; 1 selects the hs_a/ls_b diagonal |
| level_code | input | 2 | Trip level select; 2'b11 means coast |
| trip_in | input | 1 | Current comparator output, high at trip |
| zero_in | input | 1 | Winding current has reached zero |
| fault_in | input | 1 | Over-temperature, undervoltage or charge-pump fault |
| hs_a | output | 1 | High-side gate enable, leg A |
| ls_a | output | 1 | Low-side gate enable, leg A |
| hs_b | output | 1 | High-side gate enable, leg B |
| ls_b | output | 1 | Low-side gate enable, leg B |

## Verification
The bench builds the block with OFF_CYC=40, BLANK_CYC=5, XOVER_CYC=2 and DEAD_CYC=3, which gives FAST_CYC=12. An off period then lasts a few dozen cycles, so zero-detect pulses, direction changes, coast and faults can each be placed inside a chosen window of a single off period: the leading gap, the fast-decay window, the dead time or the slow-decay window. With DEAD_CYC only one cycle longer than XOVER_CYC, the crossover check on leg B runs close to its limit when slow decay begins.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

    localparam int SYS_MHZ = 50;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_GAP,
        ST_ON,
        ST_FAST,
        ST_DEAD,
        ST_SLOW
    } chop_st_e;

    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gate_t;

    localparam gate_t GATES_OFF  = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};
    localparam gate_t GATES_SLOW = '{hs_a: 1'b0, ls_a: 1'b1, hs_b: 1'b0, ls_b: 1'b1};

    function automatic int ns_to_cyc(input int ns);
        return (ns * SYS_MHZ + 999) / 1000;
    endfunction

    function automatic int permil_of(input int total, input int permil);
        return (total * permil + 500) / 1000;
    endfunction

    function automatic gate_t diag(input logic fwd);
        gate_t g;
        g.hs_a = fwd;
        g.ls_a = !fwd;
        g.hs_b = !fwd;
        g.ls_b = fwd;
        return g;
    endfunction

endpackage

// File: rtl/chop_blank.sv
`timescale 1ns/1ps
module chop_blank #(
    parameter int BLANK_CYC = 50,
    parameter int CW        = 12
) (
    input  logic          driving,
    input  logic [CW-1:0] age,
    input  logic          trip_raw,
    output logic          trip_ok
);
    always_comb begin
        trip_ok = driving && trip_raw && (age >= CW'(BLANK_CYC));
    end
endmodule

// File: rtl/chop_fsm.sv
`timescale 1ns/1ps
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 1500,
    parameter int FAST_CYC  = 452,
    parameter int DEAD_CYC  = 30,
    parameter int XOVER_CYC = 22,
    parameter int BLANK_CYC = 50,
    parameter int CW        = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir,
    input  logic          stop,
    input  logic          trip_ok,
    output chop_st_e      st,
    output logic [CW-1:0] cnt,
    output logic          drv_dir
);
    localparam logic [CW-1:0] GAP_LAST  = CW'(XOVER_CYC - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYC - 1);
    localparam logic [CW-1:0] DEAD_LAST = CW'(FAST_CYC + DEAD_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] BLANK_CAP = CW'(BLANK_CYC);

    chop_st_e nxt;
    logic     keep_count;
    logic     hold_count;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_HALT: nxt = ST_GAP;
            ST_GAP:  if (cnt == GAP_LAST) nxt = ST_ON;
            ST_ON: begin
                if (dir != drv_dir)  nxt = ST_GAP;
                else if (trip_ok)    nxt = ST_FAST;
            end
            ST_FAST: if (cnt == FAST_LAST) nxt = ST_DEAD;
            ST_DEAD: if (cnt == DEAD_LAST) nxt = ST_SLOW;
            ST_SLOW: if (cnt == OFF_LAST)  nxt = ST_GAP;
            default: nxt = ST_HALT;
        endcase
        if (stop) nxt = ST_HALT;
    end

    always_comb begin
        keep_count = (nxt == st) || (nxt == ST_DEAD) || (nxt == ST_SLOW);
        hold_count = (st == ST_HALT) || ((st == ST_ON) && (cnt >= BLANK_CAP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HALT;
            cnt     <= '0;
            drv_dir <= 1'b0;
        end else begin
            st <= nxt;
            if (!keep_count)      cnt <= '0;
            else if (!hold_count) cnt <= cnt + 1'b1;
            if (st == ST_GAP && nxt == ST_ON) drv_dir <= dir;
        end
    end
endmodule

// File: rtl/chop_gate.sv
`timescale 1ns/1ps
module chop_gate
    import chop_pkg::*;
#(
    parameter int XOVER_CYC = 22,
    parameter int CW        = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  chop_st_e      st,
    input  logic [CW-1:0] cnt,
    input  logic          drv_dir,
    input  logic          zero_det,
    output gate_t         gates,
    output logic          in_decay
);
    logic sr_kill;

    always_comb begin
        in_decay = (st == ST_FAST) || (st == ST_DEAD) || (st == ST_SLOW);
    end

    always_ff @(posedge clk) begin
        if (rst) sr_kill <= 1'b0;
        else     sr_kill <= in_decay && (sr_kill || zero_det);
    end

    always_comb begin
        gates = GATES_OFF;
        unique case (st)
            ST_ON:   gates = diag(drv_dir);
            ST_FAST: if (cnt >= CW'(XOVER_CYC) && !sr_kill) gates = diag(!drv_dir);
            ST_SLOW: if (!sr_kill) gates = GATES_SLOW;
            default: gates = GATES_OFF;
        endcase
    end
endmodule

// File: rtl/decay_chopper.sv
`timescale 1ns/1ps
module decay_chopper
    import chop_pkg::*;
#(
    parameter int OFF_CYC     = 30 * SYS_MHZ,
    parameter int BLANK_CYC   = SYS_MHZ,
    parameter int XOVER_CYC   = ns_to_cyc(425),
    parameter int DEAD_CYC    = ns_to_cyc(600),
    parameter int FAST_PERMIL = 301
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       phase_dir,
    input  logic [1:0] level_code,
    input  logic       trip_in,
    input  logic       zero_in,
    input  logic       fault_in,
    output logic       hs_a,
    output logic       ls_a,
    output logic       hs_b,
    output logic       ls_b
);
    localparam int FAST_CYC = permil_of(OFF_CYC, FAST_PERMIL);
    localparam int CW       = $clog2(OFF_CYC + BLANK_CYC + XOVER_CYC + 2);

    chop_st_e      st;
    logic [CW-1:0] cnt;
    logic          drv_dir;
    logic          trip_ok;
    logic          stop;
    logic          in_decay;
    gate_t         gates;

    always_comb begin
        stop = fault_in || (level_code == 2'b11);
    end

    chop_blank #(
        .BLANK_CYC(BLANK_CYC),
        .CW       (CW)
    ) u_blank (
        .driving (st == ST_ON),
        .age     (cnt),
        .trip_raw(trip_in),
        .trip_ok (trip_ok)
    );

    chop_fsm #(
        .OFF_CYC  (OFF_CYC),
        .FAST_CYC (FAST_CYC),
        .DEAD_CYC (DEAD_CYC),
        .XOVER_CYC(XOVER_CYC),
        .BLANK_CYC(BLANK_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .dir    (phase_dir),
        .stop   (stop),
        .trip_ok(trip_ok),
        .st     (st),
        .cnt    (cnt),
        .drv_dir(drv_dir)
    );

    chop_gate #(
        .XOVER_CYC(XOVER_CYC),
        .CW       (CW)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .cnt     (cnt),
        .drv_dir (drv_dir),
        .zero_det(zero_in),
        .gates   (gates),
        .in_decay(in_decay)
    );

    always_comb begin
        hs_a = gates.hs_a;
        ls_a = gates.ls_a;
        hs_b = gates.hs_b;
        ls_b = gates.ls_b;
    end
endmodule

// File: rtl/decay_chopper_chk.sv
`timescale 1ns/1ps
module decay_chopper_chk #(
    parameter int XOVER_CYC = 22
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] level_code,
    input logic       zero_in,
    input logic       fault_in,
    input logic       in_decay,
    input logic       hs_a,
    input logic       ls_a,
    input logic       hs_b,
    input logic       ls_b
);
    localparam logic [15:0] XMIN = 16'(XOVER_CYC);

    logic [15:0] idle_hs_a, idle_ls_a, idle_hs_b, idle_ls_b;
    logic        all_off;

    always_comb all_off = !(hs_a || ls_a || hs_b || ls_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_hs_a <= '0;
            idle_ls_a <= '0;
            idle_hs_b <= '0;
            idle_ls_b <= '0;
        end else begin
            idle_hs_a <= hs_a ? 16'd0 : (idle_hs_a == 16'hFFFF ? idle_hs_a : idle_hs_a + 16'd1);
            idle_ls_a <= ls_a ? 16'd0 : (idle_ls_a == 16'hFFFF ? idle_ls_a : idle_ls_a + 16'd1);
            idle_hs_b <= hs_b ? 16'd0 : (idle_hs_b == 16'hFFFF ? idle_hs_b : idle_hs_b + 16'd1);
            idle_ls_b <= ls_b ? 16'd0 : (idle_ls_b == 16'hFFFF ? idle_ls_b : idle_ls_b + 16'd1);
        end
    end

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        !(hs_a && ls_a) && !(hs_b && ls_b)); // R11
    AST_XOVER_HS_A: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_a) |-> idle_ls_a >= XMIN); // R11
    AST_XOVER_LS_A: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_a) |-> idle_hs_a >= XMIN); // R11
    AST_XOVER_HS_B: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_b) |-> idle_ls_b >= XMIN); // R11
    AST_XOVER_LS_B: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_b) |-> idle_hs_b >= XMIN); // R11
    AST_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hs_a, hs_b})); // R2
    AST_SR_CUT: assert property (@(posedge clk) disable iff (rst)
        (in_decay && zero_in) |=> all_off); // R7
    AST_COAST_OFF: assert property (@(posedge clk) disable iff (rst)
        (level_code == 2'b11) |=> all_off); // R9
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
        fault_in |=> all_off); // R10
endmodule

bind decay_chopper decay_chopper_chk #(.XOVER_CYC(XOVER_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .level_code(level_code),
    .zero_in   (zero_in),
    .fault_in  (fault_in),
    .in_decay  (in_decay),
    .hs_a      (hs_a),
    .ls_a      (ls_a),
    .hs_b      (hs_b),
    .ls_b      (ls_b)
);

// File: tb/sim_decay_chopper.sv
`timescale 1ns/1ps
module sim_decay_chopper;
    localparam int P_OFF   = 40;
    localparam int P_BLANK = 5;
    localparam int P_XOVER = 2;
    localparam int P_DEAD  = 3;
    localparam int P_FAST  = (P_OFF * 301 + 500) / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phase_dir = 1'b1;
    logic [1:0] level_code = 2'b00;
    logic       trip_in = 1'b0;
    logic       zero_in = 1'b0;
    logic       fault_in = 1'b0;
    logic       hs_a, ls_a, hs_b, ls_b;

    int    checks = 0;
    int    bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference: elapsed-time trackers, -1 when inactive
    bit m_halt = 1'b1;
    bit m_kill = 1'b0;
    bit m_dir  = 1'b0;
    int gap_t = -1;
    int on_t  = -1;
    int off_t = -1;

    always #2 clk = ~clk;

    decay_chopper #(
        .OFF_CYC  (P_OFF),
        .BLANK_CYC(P_BLANK),
        .XOVER_CYC(P_XOVER),
        .DEAD_CYC (P_DEAD)
    ) u0 (
        .clk(clk), .rst(rst), .phase_dir(phase_dir), .level_code(level_code),
        .trip_in(trip_in), .zero_in(zero_in), .fault_in(fault_in),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    always @(posedge clk) begin
        cyc++;
        if (rst || fault_in || level_code == 2'b11) begin
            m_halt = 1'b1; gap_t = -1; on_t = -1; off_t = -1; m_kill = 1'b0;
        end else if (m_halt) begin
            m_halt = 1'b0; gap_t = 0;
        end else if (gap_t >= 0) begin
            if (gap_t == P_XOVER - 1) begin
                gap_t = -1; on_t = 0; m_dir = phase_dir;
            end else gap_t++;
        end else if (on_t >= 0) begin
            if (phase_dir != m_dir) begin
                on_t = -1; gap_t = 0;
            end else if (trip_in && on_t >= P_BLANK) begin
                on_t = -1; off_t = 0; m_kill = 1'b0;
            end else if (on_t < 1000) on_t++;
        end else if (off_t >= 0) begin
            if (zero_in) m_kill = 1'b1;
            if (off_t == P_OFF - 1) begin
                off_t = -1; gap_t = 0;
            end else off_t++;
        end
    end

    function automatic logic [3:0] expect_gates();
        if (on_t >= 0) return m_dir ? 4'b1001 : 4'b0110;
        if (off_t >= 0) begin
            if (off_t < P_XOVER) return 4'b0000;
            if (off_t < P_FAST) return m_kill ? 4'b0000 : (m_dir ? 4'b0110 : 4'b1001);
            if (off_t < P_FAST + P_DEAD) return 4'b0000;
            return m_kill ? 4'b0000 : 4'b0101;
        end
        return 4'b0000;
    endfunction

    always @(negedge clk) begin
        logic [3:0] got;
        logic [3:0] exp_g;
        got = {hs_a, ls_a, hs_b, ls_b};
        exp_g = expect_gates();
        checks++;
        if (got !== exp_g) begin
            bad++;
            $display("FAIL %s cycle=%0d got=%b exp=%b", cur_req, cyc, got, exp_g);
        end
        checks++;
        if ((hs_a && ls_a) || (hs_b && ls_b)) begin
            bad++;
            $display("FAIL R11 cycle=%0d got=%b exp=no leg shorted", cyc, got);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trip();
        trip_in = 1'b1;
        step(1);
        trip_in = 1'b0;
    endtask

    initial begin
        step(3);
        cur_req = "R1";
        checks++;
        if ({hs_a, ls_a, hs_b, ls_b} !== 4'b0000) begin
            bad++;
            $display("FAIL R1 reset got=%b exp=0000", {hs_a, ls_a, hs_b, ls_b});
        end
        rst = 1'b0;
        cur_req = "R3";
        trip_in = 1'b1;         // held through the blanking window only
        step(6);
        trip_in = 1'b0;
        step(8);
        cur_req = "R4";
        pulse_trip();
        cur_req = "R5";
        step(14);
        cur_req = "R6";
        step(30);
        cur_req = "R4";
        step(12);
        cur_req = "R7";          // zero during fast decay
        pulse_trip();
        step(4);
        zero_in = 1'b1; step(1); zero_in = 1'b0;
        step(50);
        pulse_trip();            // zero during slow decay
        step(25);
        zero_in = 1'b1; step(1); zero_in = 1'b0;
        step(30);
        cur_req = "R8";
        phase_dir = 1'b0;
        step(4);
        cur_req = "R2";
        step(8);
        cur_req = "R5";
        pulse_trip();
        step(20);
        cur_req = "R8";
        phase_dir = 1'b1;
        step(40);
        cur_req = "R9";
        level_code = 2'b11; step(6);
        level_code = 2'b01; step(12);
        level_code = 2'b10; step(8);
        level_code = 2'b00;
        cur_req = "R10";
        pulse_trip();
        step(6);
        fault_in = 1'b1; step(4); fault_in = 1'b0;
        step(15);
        fault_in = 1'b1; step(2); fault_in = 1'b0;
        step(12);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog cycle=%0d got=running exp=finished", cyc);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule